// File: doc/BRIEF.md
# Transmit Descriptor Buffer Walker

This block takes a transmit DMA descriptor whose words have already been fetched into registers. It turns the descriptor into an ordered series of buffer transfer requests for a downstream data mover, then works out where the next descriptor lives. A start strobe captures the control word, the size word, both pointer words, the current descriptor address, the ring base and the captured 64-bit frame timestamp. The walker then issues at most two (address, length) requests over a valid/ready handshake. When the descriptor asks for it, the walker also issues a timestamp write-back request. It ends with a one-cycle done pulse, and the next-descriptor address is valid during that pulse.

The descriptor can work in two ways. In ring mode, word 3 is a second data buffer and the next descriptor follows the current one in memory. The ring can also wrap to its base. In chained mode, word 3 points to the next descriptor, and the second size field carries no meaning. A size of zero causes that buffer to be skipped. A chained pointer that is not word aligned makes the walker abort the descriptor with an error flag.

Top module: `tx_desc_walker`

## Requirements
- R1: After reset, reqValid, wbValid, doneOut and alignErr are all low.
- R2: The buffer 1 length is sizeWord[12:0] and the buffer 2 length is sizeWord[28:16]. Bits 15:13 are ignored. Buffer 1 is requested at word2 exactly, with any byte alignment.
- R3: If the buffer 1 length is zero, no request is issued for buffer 1, and processing moves on to buffer 2 or to the end of the descriptor.
- R4: In ring mode (ctlWord[20] = 0), a buffer 2 with a nonzero length is requested at word3 after buffer 1. A buffer 2 with a zero length is skipped. In ring mode, word3 may have any alignment.
- R5: In chained mode (ctlWord[20] = 1), no buffer 2 request is ever issued, whatever the size field holds, and the next-descriptor address is word3.
- R6: In ring mode, the next-descriptor address is curAddr + 32. If the end-of-ring bit ctlWord[21] is set, it is ringBase instead.
- R7: In chained mode, a word3 with bits 1:0 nonzero sets alignErr. No buffer request and no write-back is then issued, and doneOut still pulses. alignErr stays set until the next accepted start.
- R8: A write-back request is issued only when ctlWord[29] (last segment) and ctlWord[17] (timestamp enable) are both 1. It comes after all buffer requests and carries wbAddr = curAddr + 24, wbLow = tsValue[31:0] and wbHigh = tsValue[63:32].
- R9: A request that is held back by a low ready keeps its valid, address and length unchanged until the cycle in which it is accepted.
- R10: doneOut is high for exactly one cycle, in the cycle after the last handshake completes (or after the decision when there is nothing to issue). nextAddr is valid while doneOut is high.
- R11: A start strobe that arrives while a descriptor is being walked is ignored. The descriptor in progress completes with its original values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Start strobe; words are captured when idle |
| ctlWord | input | 32 | Descriptor word 0 (control) |
| sizeWord | input | 32 | Descriptor word 1 (two byte counts) |
| buf1Ptr | input | 32 | Descriptor word 2 (buffer 1 address) |
| buf2Ptr | input | 32 | Descriptor word 3 (buffer 2 or next pointer) |
| curAddr | input | 32 | Address of the current descriptor |
| ringBase | input | 32 | Ring start address used on wrap |
| tsValue | input | 64 | Captured frame timestamp |
| reqValid | output | 1 | Buffer request valid |
| reqReady | input | 1 | Data mover accepts the request |
| reqAddr | output | 32 | Buffer request address |
| reqLen | output | 13 | Buffer request byte count |
| wbValid | output | 1 | Timestamp write-back valid |
| wbReady | input | 1 | Write-back accepted |
| wbAddr | output | 32 | Address of the low timestamp word |
| wbLow | output | 32 | Low 32 bits of the timestamp |
| wbHigh | output | 32 | High 32 bits of the timestamp |
| nextAddr | output | 32 | Next descriptor address |
| alignErr | output | 1 | Misaligned chain pointer flag |
| doneOut | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the skip paths: a zero buffer 1 ahead of a live buffer 2, a chained descriptor whose second size field is nonzero, and a descriptor with nothing to move at all. A design that got these wrong would request a zero-byte transfer, or would treat a chain pointer as data. Reserved bits set inside the size word catch a length field that is too wide. A misaligned word3 in ring mode catches an alignment check applied in every mode. The write-back is tried with each of its two enable bits alone, and a wrong gate would emit a stray write-back. Stalls on ready and a second start during a stall expose a request that changes while stalled, or a walker that restarts in the middle of a descriptor.

// File: rtl/txdw_pkg.sv
`timescale 1ns/1ps
package txdw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECIDE,
    ST_BUF1,
    ST_BUF2,
    ST_WB,
    ST_DONE
  } walkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latch;
    logic setErr;
    logic selBuf2;
  } dpCtl_t;

  // decoded facts about the captured descriptor
  typedef struct packed {
    logic hasBuf1;
    logic hasBuf2;
    logic doWb;
    logic badAlign;
  } dpFlags_t;

endpackage

// File: rtl/txdw_datapath.sv
`timescale 1ns/1ps
module txdw_datapath
  import txdw_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LEN_W      = 13,
  parameter int LEN2_LSB   = 16,
  parameter int CHAIN_BIT  = 20,
  parameter int EOR_BIT    = 21,
  parameter int LAST_BIT   = 29,
  parameter int TSE_BIT    = 17,
  parameter int DESC_BYTES = 32,
  parameter int WB_OFFSET  = 24,
  parameter int ALIGN_BITS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic [WORD_W-1:0] ctlWord,
  input  logic [WORD_W-1:0] sizeWord,
  input  logic [ADDR_W-1:0] buf1Ptr,
  input  logic [ADDR_W-1:0] buf2Ptr,
  input  logic [ADDR_W-1:0] curAddr,
  input  logic [ADDR_W-1:0] ringBase,
  input  logic [2*WORD_W-1:0] tsValue,
  output dpFlags_t          flags,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [LEN_W-1:0]  reqLen,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [WORD_W-1:0] wbLow,
  output logic [WORD_W-1:0] wbHigh,
  output logic [ADDR_W-1:0] nextAddr,
  output logic              alignErr
);

  localparam logic [ADDR_W-1:0] DESC_STEP = ADDR_W'(DESC_BYTES);
  localparam logic [ADDR_W-1:0] WB_STEP   = ADDR_W'(WB_OFFSET);

  logic              chainR, eorR, tsGateR, errR;
  logic [LEN_W-1:0]  len1R, len2R;
  logic [ADDR_W-1:0] ptr1R, ptr2R, curR, baseR;
  logic [2*WORD_W-1:0] tsR;

  // bits of the words this block never looks at
  logic unusedBits;
  assign unusedBits = ^{ctlWord, sizeWord};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chainR  <= 1'b0;
      eorR    <= 1'b0;
      tsGateR <= 1'b0;
      len1R   <= '0;
      len2R   <= '0;
      ptr1R   <= '0;
      ptr2R   <= '0;
      curR    <= '0;
      baseR   <= '0;
      tsR     <= '0;
    end else if (dpCtl.latch) begin
      chainR  <= ctlWord[CHAIN_BIT];
      eorR    <= ctlWord[EOR_BIT];
      tsGateR <= ctlWord[LAST_BIT] & ctlWord[TSE_BIT];
      len1R   <= sizeWord[LEN_W-1:0];
      len2R   <= sizeWord[LEN2_LSB +: LEN_W];
      ptr1R   <= buf1Ptr;
      ptr2R   <= buf2Ptr;
      curR    <= curAddr;
      baseR   <= ringBase;
      tsR     <= tsValue;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              errR <= 1'b0;
    else if (dpCtl.latch)   errR <= 1'b0;
    else if (dpCtl.setErr)  errR <= 1'b1;
  end

  always_comb begin
    flags.hasBuf1  = (len1R != '0);
    flags.hasBuf2  = !chainR && (len2R != '0);
    flags.doWb     = tsGateR;
    flags.badAlign = chainR && (ptr2R[ALIGN_BITS-1:0] != '0);
  end

  assign reqAddr  = dpCtl.selBuf2 ? ptr2R : ptr1R;
  assign reqLen   = dpCtl.selBuf2 ? len2R : len1R;
  assign wbAddr   = curR + WB_STEP;
  assign wbLow    = tsR[WORD_W-1:0];
  assign wbHigh   = tsR[2*WORD_W-1:WORD_W];
  assign nextAddr = chainR ? ptr2R : (eorR ? baseR : curR + DESC_STEP);
  assign alignErr = errR;

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errR && !dpCtl.latch |=> errR);

endmodule

// File: rtl/txdw_ctrl.sv
`timescale 1ns/1ps
module txdw_ctrl
  import txdw_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startIn,
  input  dpFlags_t flags,
  input  logic     reqReady,
  input  logic     wbReady,
  output dpCtl_t   dpCtl,
  output logic     reqValid,
  output logic     wbValid,
  output logic     doneOut
);

  walkState_t state, stateNxt;

  // where to go once buffer 1 is behind us
  function automatic walkState_t afterBuf1(dpFlags_t f);
    if (f.hasBuf2)   return ST_BUF2;
    else if (f.doWb) return ST_WB;
    else             return ST_DONE;
  endfunction

  always_comb begin
    stateNxt      = state;
    dpCtl.latch   = 1'b0;
    dpCtl.setErr  = 1'b0;
    dpCtl.selBuf2 = (state == ST_BUF2);
    unique case (state)
      ST_IDLE: begin
        if (startIn) begin
          dpCtl.latch = 1'b1;
          stateNxt    = ST_DECIDE;
        end
      end
      ST_DECIDE: begin
        if (flags.badAlign) begin
          dpCtl.setErr = 1'b1;
          stateNxt     = ST_DONE;
        end else if (flags.hasBuf1) begin
          stateNxt = ST_BUF1;
        end else begin
          stateNxt = afterBuf1(flags);
        end
      end
      ST_BUF1:  if (reqReady) stateNxt = afterBuf1(flags);
      ST_BUF2:  if (reqReady) stateNxt = flags.doWb ? ST_WB : ST_DONE;
      ST_WB:    if (wbReady)  stateNxt = ST_DONE;
      ST_DONE:  stateNxt = ST_IDLE;
      default:  stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign reqValid = (state == ST_BUF1) || (state == ST_BUF2);
  assign wbValid  = (state == ST_WB);
  assign doneOut  = (state == ST_DONE);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  // R11
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> !dpCtl.latch);

  // R8
  wb_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> !reqValid);

endmodule

// File: rtl/tx_desc_walker.sv
`timescale 1ns/1ps
module tx_desc_walker
  import txdw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int LEN_W  = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic [WORD_W-1:0] ctlWord,
  input  logic [WORD_W-1:0] sizeWord,
  input  logic [ADDR_W-1:0] buf1Ptr,
  input  logic [ADDR_W-1:0] buf2Ptr,
  input  logic [ADDR_W-1:0] curAddr,
  input  logic [ADDR_W-1:0] ringBase,
  input  logic [2*WORD_W-1:0] tsValue,
  output logic              reqValid,
  input  logic              reqReady,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [LEN_W-1:0]  reqLen,
  output logic              wbValid,
  input  logic              wbReady,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [WORD_W-1:0] wbLow,
  output logic [WORD_W-1:0] wbHigh,
  output logic [ADDR_W-1:0] nextAddr,
  output logic              alignErr,
  output logic              doneOut
);

  dpCtl_t   dpCtl;
  dpFlags_t flags;

  txdw_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startIn  (startIn),
    .flags    (flags),
    .reqReady (reqReady),
    .wbReady  (wbReady),
    .dpCtl    (dpCtl),
    .reqValid (reqValid),
    .wbValid  (wbValid),
    .doneOut  (doneOut)
  );

  txdw_datapath #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W),
    .LEN_W  (LEN_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .dpCtl    (dpCtl),
    .ctlWord  (ctlWord),
    .sizeWord (sizeWord),
    .buf1Ptr  (buf1Ptr),
    .buf2Ptr  (buf2Ptr),
    .curAddr  (curAddr),
    .ringBase (ringBase),
    .tsValue  (tsValue),
    .flags    (flags),
    .reqAddr  (reqAddr),
    .reqLen   (reqLen),
    .wbAddr   (wbAddr),
    .wbLow    (wbLow),
    .wbHigh   (wbHigh),
    .nextAddr (nextAddr),
    .alignErr (alignErr)
  );

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqReady |=> reqValid && $stable(reqAddr) && $stable(reqLen));

  // R3
  no_zero_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> reqLen != '0);

  // R7
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    alignErr |-> !reqValid && !wbValid);

endmodule

// File: tb/tx_desc_walker_bench.sv
`timescale 1ns/1ps
module tx_desc_walker_bench;

  typedef struct packed {
    logic [31:0] ctl;
    logic [31:0] size;
    logic [31:0] b1;
    logic [31:0] b2;
    logic [1:0]  nReq;
    logic [31:0] a0;
    logic [31:0] l0;
    logic [31:0] a1;
    logic [31:0] l1;
    logic        wb;
    logic        err;
    logic [31:0] next;
  } vec_t;

  localparam int NV = 12;
  localparam logic [31:0] CUR  = 32'h1000;
  localparam logic [31:0] BASE = 32'h0800;
  localparam logic [63:0] TS   = 64'h1122_3344_5566_7788;

  localparam vec_t VECS [NV] = '{
    // R2 R4: ring, two buffers, odd buffer 1 address
    '{32'h0, 32'h0020_0040, 32'h2001, 32'h3000, 2'd2, 32'h2001, 32'h40, 32'h3000, 32'h20, 1'b0, 1'b0, 32'h1020},
    // R3 R4: zero buffer 1, misaligned word3 fine in ring
    '{32'h0, 32'h0010_0000, 32'h2000, 32'h3003, 2'd1, 32'h3003, 32'h10, 32'h0, 32'h0, 1'b0, 1'b0, 32'h1020},
    // R6: end of ring wraps, max length, zero buffer 2
    '{32'h0020_0000, 32'h0000_1FFF, 32'h2004, 32'h3000, 2'd1, 32'h2004, 32'h1FFF, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0800},
    // R5: chained, size2 ignored
    '{32'h0010_0000, 32'h0055_0008, 32'h2002, 32'h4000, 2'd1, 32'h2002, 32'h8, 32'h0, 32'h0, 1'b0, 1'b0, 32'h4000},
    // R3 R5: chained, nothing to move
    '{32'h0010_0000, 32'h0055_0000, 32'h2000, 32'h4000, 2'd0, 32'h0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h4000},
    // R7: chained, misaligned pointer
    '{32'h2012_0000, 32'h0000_0008, 32'h2000, 32'h4002, 2'd0, 32'h0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b1, 32'h4002},
    // R8: ring, both gate bits
    '{32'h2002_0000, 32'h0004_0004, 32'h2000, 32'h3000, 2'd2, 32'h2000, 32'h4, 32'h3000, 32'h4, 1'b1, 1'b0, 32'h1020},
    // R8: last segment only
    '{32'h2000_0000, 32'h0000_0004, 32'h2000, 32'h3000, 2'd1, 32'h2000, 32'h4, 32'h0, 32'h0, 1'b0, 1'b0, 32'h1020},
    // R8: timestamp enable only
    '{32'h0002_0000, 32'h0000_0004, 32'h2000, 32'h3000, 2'd1, 32'h2000, 32'h4, 32'h0, 32'h0, 1'b0, 1'b0, 32'h1020},
    // R8: chained, no buffers, write-back only
    '{32'h2012_0000, 32'h0000_0000, 32'h2000, 32'h4000, 2'd0, 32'h0, 32'h0, 32'h0, 32'h0, 1'b1, 1'b0, 32'h4000},
    // R2: reserved bits 15:13 set
    '{32'h0020_0000, 32'h0000_E010, 32'h2000, 32'h3000, 2'd1, 32'h2000, 32'h10, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0800},
    // R3 R4: ring, both sizes zero
    '{32'h0, 32'h0, 32'h2000, 32'h3000, 2'd0, 32'h0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h1020}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startIn = 1'b0;
  logic [31:0] ctlWord = '0, sizeWord = '0, buf1Ptr = '0, buf2Ptr = '0;
  logic [31:0] curAddr = CUR, ringBase = BASE;
  logic [63:0] tsValue = TS;
  logic        reqReady = 1'b0, wbReady = 1'b0;
  logic        reqValid, wbValid, alignErr, doneOut;
  logic [31:0] reqAddr, wbAddr, wbLow, wbHigh, nextAddr;
  logic [12:0] reqLen;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  tx_desc_walker u_tx_desc_walker (
    .clk(clk), .rstN(rstN), .startIn(startIn),
    .ctlWord(ctlWord), .sizeWord(sizeWord), .buf1Ptr(buf1Ptr), .buf2Ptr(buf2Ptr),
    .curAddr(curAddr), .ringBase(ringBase), .tsValue(tsValue),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr), .reqLen(reqLen),
    .wbValid(wbValid), .wbReady(wbReady), .wbAddr(wbAddr), .wbLow(wbLow), .wbHigh(wbHigh),
    .nextAddr(nextAddr), .alignErr(alignErr), .doneOut(doneOut)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finishRun();
  end

  task automatic loadVec(input vec_t v);
    ctlWord  = v.ctl;
    sizeWord = v.size;
    buf1Ptr  = v.b1;
    buf2Ptr  = v.b2;
  endtask

  task automatic runVec(input vec_t v, input int idx);
    logic [31:0] gA [2];
    logic [31:0] gL [2];
    int   nGot = 0;
    int   nWb = 0;
    int   doneSeen = 0;
    logic stalled = 1'b0;
    logic [31:0] heldA = '0;
    @(negedge clk);
    loadVec(v);
    startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      cyc++;
      if (stalled) begin
        // R9: stalled request unchanged
        check($sformatf("R9 hold v%0d", idx), {reqValid, reqAddr}, {1'b1, heldA});
      end
      reqReady = (cyc % 3) != 0;
      wbReady  = (cyc % 4) != 0;
      stalled  = reqValid && !reqReady;
      heldA    = reqAddr;
      if (reqValid && reqReady) begin
        if (nGot < 2) begin
          gA[nGot] = reqAddr;
          gL[nGot] = 32'(reqLen);
        end
        nGot++;
      end
      if (wbValid && wbReady) begin
        nWb++;
        // R8: write-back after all buffers, fixed address and data split
        check($sformatf("R8 wb order v%0d", idx), 64'(nGot), 64'(v.nReq));
        check($sformatf("R8 wb data v%0d", idx), {wbLow, wbHigh}, {TS[31:0], TS[63:32]});
        check($sformatf("R8 wb addr v%0d", idx), 64'(wbAddr), 64'(CUR + 32'd24));
      end
      if (doneOut) begin
        doneSeen = 1;
        break;
      end
    end
    reqReady = 1'b0;
    wbReady  = 1'b0;
    check($sformatf("R10 done v%0d", idx), 64'(doneSeen), 64'd1);
    check($sformatf("R2 R3 R4 R5 count v%0d", idx), 64'(nGot), 64'(v.nReq));
    if (nGot >= 1 && v.nReq >= 1)
      check($sformatf("R2 R3 first v%0d", idx), {gA[0], gL[0]}, {v.a0, v.l0});
    if (nGot >= 2 && v.nReq >= 2)
      check($sformatf("R4 second v%0d", idx), {gA[1], gL[1]}, {v.a1, v.l1});
    check($sformatf("R8 wb count v%0d", idx), 64'(nWb), 64'(v.wb));
    check($sformatf("R7 err v%0d", idx), 64'(alignErr), 64'(v.err));
    check($sformatf("R5 R6 next v%0d", idx), 64'(nextAddr), 64'(v.next));
    @(negedge clk);
    // R10: pulse is a single cycle
    check($sformatf("R10 single v%0d", idx), 64'(doneOut), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset", {60'd0, reqValid, wbValid, doneOut, alignErr}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", {60'd0, reqValid, wbValid, doneOut, alignErr}, 64'd0);

    for (int i = 0; i < NV; i++) runVec(VECS[i], i);

    // R7: error clears on next accepted start
    runVec(VECS[5], 100);
    runVec(VECS[0], 101);

    // R11: start during a stalled walk is ignored
    @(negedge clk);
    loadVec(VECS[0]);
    startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    repeat (3) @(negedge clk);
    loadVec(VECS[3]);
    startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    check("R11 first kept", {reqValid, reqAddr, 19'd0, reqLen}, {1'b1, 32'h2001, 19'd0, 13'h40});
    reqReady = 1'b1;
    @(negedge clk);
    check("R11 second kept", {reqValid, reqAddr, 19'd0, reqLen}, {1'b1, 32'h3000, 19'd0, 13'h20});
    @(negedge clk);
    reqReady = 1'b0;
    check("R11 done", {doneOut, nextAddr}, {1'b1, 32'h1020});
    @(negedge clk);
    check("R11 idle after", {reqValid, doneOut}, 2'b00);

    finishRun();
  end

endmodule